// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block brings an Ethernet PHY from reset to a negotiated link without software. After a start request it issues a fixed series of register reads and writes over a request/acknowledge command port, which an MDIO management master carries out. The series has five stages. First it soft-resets the PHY and waits for the reset bit to clear. It then masks every PHY interrupt and reads the ability bits from the status register. From those bits it builds the advertisement word, writes it and reads it back once. Finally it restarts auto-negotiation and polls the status register until negotiation completes.

The waits between polls come from an interval counter. By default the interval is half a second at 100 MHz, and a parameter can shorten it for simulation. Reset polling gives up after a fixed number of attempts. Negotiation polling gives up after twice the configured timeout in seconds. When a poll reports a remote fault, negotiation is kicked again with the speed and duplex bits also set. Every run ends with a single-cycle `done_o`, a `fail_o` verdict and the last status word read.

Top module: `phy_bringup_seq`

## Requirements
- R1: The first command after an accepted start is a write of 0x8000 (bit 15, reset) to the control register (parameter REG_CTRL, default 0).
- R2: The control register is then read. If bit 15 reads back as 1, the block waits at least one interval of TICK_CYCLES clocks and reads it again. If bit 15 reads as 0, the sequence moves on.
- R3: If RST_POLLS control reads in a row all show bit 15 set, the run ends at once with fail_o = 1 and status_o = 0, and no further command is issued.
- R4: After reset completes, 0xFFFF is written to the interrupt mask register (REG_MASK, default 19). The status register (REG_STAT, default 1) is then read once to obtain the ability bits.
- R5: The advertisement register (REG_ADV, default 4) is written with bit 0 always set. Bits 9, 8, 7, 6 and 5 copy status bits 15, 14, 13, 12 and 11. All other bits are 0.
- R6: The advertisement register is then read once and the value discarded. Next, the control register is written with 0x1200 (bits 12 and 9).
- R7: The status register is then polled, at least one interval apart. When a poll shows bit 5 (negotiation complete) set, the run ends, status_o holds that word, and fail_o equals its bit 4 (remote fault).
- R8: When an incomplete poll shows bit 4 set, the block writes the control register with 0x3300 (bits 13, 12, 9, 8) after the interval. It then polls again.
- R9: If 2*AN_TIMEOUT_S polls all show bit 5 clear, the run ends with fail_o = 1.
- R10: A completing poll that also shows bit 4 ends the run with fail_o = 1.
- R11: done_o is high for exactly one cycle per run. A start request while a run is in progress has no effect.
- R12: While cmd_req_o is high and cmd_ack_i is low, cmd_req_o stays high and cmd_wr_o, cmd_reg_o and cmd_wdata_o stay unchanged.
- R13: Out of reset, cmd_req_o, done_o and fail_o are 0 and status_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up run (honoured only when idle) |
| cmd_req_o | output | 1 | Command request to the management master |
| cmd_wr_o | output | 1 | 1 = register write, 0 = register read |
| cmd_reg_o | output | 5 | PHY register number |
| cmd_wdata_o | output | 16 | Write data (0 for reads) |
| cmd_ack_i | input | 1 | Command accepted and completed this cycle |
| cmd_rdata_i | input | 16 | Read data, valid with cmd_ack_i |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Verdict of the last run, held until next start |
| status_o | output | 16 | Last status word read |

## Verification
The bench aims at the edges of both poll limits:
- A reset bit that clears only on the final allowed read must still lead to configuration. An off-by-one counter would abort that run, or let a seventh read through.
- A negotiation that never completes must fail after exactly the configured number of polls.
- A completing poll that also carries a remote fault must fail. A design that looked only at the complete bit would report success.

Remote faults on intermediate polls must each produce a control rewrite with speed and duplex set. Advertisement words are checked against randomly drawn ability bits, so a misplaced bit in the mapping shows up as a wrong write value. A start pulse injected mid-run must leave the command sequence untouched.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  // control register bits
  localparam int CTL_RESET   = 15;
  localparam int CTL_SPEED   = 13;
  localparam int CTL_ANEN    = 12;
  localparam int CTL_ANRST   = 9;
  localparam int CTL_DUPLEX  = 8;

  // status register bits
  localparam int STS_ANDONE  = 5;
  localparam int STS_RFAULT  = 4;
  localparam int STS_ABIL_HI = 15;   // abilities occupy 15 downto 11
  localparam int ADV_ABIL_HI = 9;    // advertised abilities occupy 9 downto 5
  localparam int ABIL_COUNT  = 5;

  localparam logic [15:0] WORD_RESET   = 16'h1 << CTL_RESET;
  localparam logic [15:0] WORD_ANSTART = (16'h1 << CTL_ANEN) | (16'h1 << CTL_ANRST);
  localparam logic [15:0] WORD_ANFORCE = WORD_ANSTART | (16'h1 << CTL_SPEED) | (16'h1 << CTL_DUPLEX);
  localparam logic [15:0] WORD_MASKALL = 16'hFFFF;
  localparam logic [15:0] WORD_SELECT  = 16'h0001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_WR,
    ST_RST_RD,
    ST_RST_WAIT,
    ST_MASK_WR,
    ST_ABIL_RD,
    ST_ADV_WR,
    ST_ADV_RD,
    ST_AN_WR,
    ST_AN_RD,
    ST_AN_WAIT,
    ST_FLT_WR,
    ST_FINISH
  } seq_state_e;

endpackage

// File: rtl/bringup_interval_timer.sv
module bringup_interval_timer #(
  parameter int unsigned TICK_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CNT_W = $clog2(TICK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_o) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0)) else $error("interval counter did not wrap"); // R2

endmodule

// File: rtl/bringup_adv_map.sv
module bringup_adv_map
  import phy_bringup_pkg::*;
(
  input  logic [15:0] ability_i,
  output logic [15:0] adv_o
);

  logic [15:0] abil_bits;

  for (genvar k = 0; k < 16; k++) begin : g_bit
    if (k <= ADV_ABIL_HI && k > ADV_ABIL_HI - ABIL_COUNT) begin : g_copy
      assign abil_bits[k] = ability_i[k + (STS_ABIL_HI - ADV_ABIL_HI)];
    end else begin : g_zero
      assign abil_bits[k] = 1'b0;
    end
  end

  assign adv_o = abil_bits | WORD_SELECT;

endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import phy_bringup_pkg::*;
#(
  parameter int          RST_POLLS = 6,
  parameter int          AN_POLLS  = 10,
  parameter logic [4:0]  REG_CTRL  = 5'd0,
  parameter logic [4:0]  REG_STAT  = 5'd1,
  parameter logic [4:0]  REG_ADV   = 5'd4,
  parameter logic [4:0]  REG_MASK  = 5'd19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        tick_i,
  output logic        run_o,
  input  logic [15:0] adv_i,
  output logic        cmd_req_o,
  output logic        cmd_wr_o,
  output logic [4:0]  cmd_reg_o,
  output logic [15:0] cmd_wdata_o,
  input  logic        cmd_ack_i,
  input  logic [15:0] cmd_rdata_i,
  output logic        done_o,
  output logic        fail_o,
  output logic [15:0] status_o
);

  localparam int MAXP = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
  localparam int PW   = $clog2(MAXP + 1);
  localparam logic [PW-1:0] RST_LAST = PW'(RST_POLLS - 1);
  localparam logic [PW-1:0] AN_LAST  = PW'(AN_POLLS - 1);

  seq_state_e       state_q, state_d;
  logic [PW-1:0]    poll_q, poll_d;
  logic [15:0]      stat_q, stat_d;
  logic             fail_q, fail_d;
  logic             poll_en, stat_en, fail_en;
  logic             xfer;

  assign xfer     = cmd_req_o && cmd_ack_i;
  assign run_o    = (state_q == ST_RST_WAIT) || (state_q == ST_AN_WAIT);
  assign done_o   = (state_q == ST_FINISH);
  assign fail_o   = fail_q;
  assign status_o = stat_q;

  // command decode from the registered state
  always_comb begin
    cmd_req_o   = 1'b1;
    cmd_wr_o    = 1'b0;
    cmd_reg_o   = REG_CTRL;
    cmd_wdata_o = '0;
    unique case (state_q)
      ST_RST_WR:  begin cmd_wr_o = 1'b1; cmd_wdata_o = WORD_RESET; end
      ST_RST_RD:  cmd_reg_o = REG_CTRL;
      ST_MASK_WR: begin cmd_wr_o = 1'b1; cmd_reg_o = REG_MASK; cmd_wdata_o = WORD_MASKALL; end
      ST_ABIL_RD: cmd_reg_o = REG_STAT;
      ST_ADV_WR:  begin cmd_wr_o = 1'b1; cmd_reg_o = REG_ADV; cmd_wdata_o = adv_i; end
      ST_ADV_RD:  cmd_reg_o = REG_ADV;
      ST_AN_WR:   begin cmd_wr_o = 1'b1; cmd_wdata_o = WORD_ANSTART; end
      ST_AN_RD:   cmd_reg_o = REG_STAT;
      ST_FLT_WR:  begin cmd_wr_o = 1'b1; cmd_wdata_o = WORD_ANFORCE; end
      default:    cmd_req_o = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    poll_d  = poll_q;
    stat_d  = stat_q;
    fail_d  = fail_q;
    poll_en = 1'b0;
    stat_en = 1'b0;
    fail_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST_WR;
        stat_d  = '0;  stat_en = 1'b1;
        fail_d  = 1'b0; fail_en = 1'b1;
      end
      ST_RST_WR: if (xfer) begin
        state_d = ST_RST_RD;
        poll_d  = '0; poll_en = 1'b1;
      end
      ST_RST_RD: if (xfer) begin
        if (!cmd_rdata_i[CTL_RESET]) begin
          state_d = ST_MASK_WR;
        end else if (poll_q == RST_LAST) begin
          state_d = ST_FINISH;
          fail_d  = 1'b1; fail_en = 1'b1;
        end else begin
          state_d = ST_RST_WAIT;
          poll_d  = poll_q + 1'b1; poll_en = 1'b1;
        end
      end
      ST_RST_WAIT: if (tick_i) state_d = ST_RST_RD;
      ST_MASK_WR:  if (xfer) state_d = ST_ABIL_RD;
      ST_ABIL_RD: if (xfer) begin
        state_d = ST_ADV_WR;
        stat_d  = cmd_rdata_i; stat_en = 1'b1;
      end
      ST_ADV_WR: if (xfer) state_d = ST_ADV_RD;
      ST_ADV_RD: if (xfer) state_d = ST_AN_WR;
      ST_AN_WR: if (xfer) begin
        state_d = ST_AN_RD;
        poll_d  = '0; poll_en = 1'b1;
      end
      ST_AN_RD: if (xfer) begin
        stat_d = cmd_rdata_i; stat_en = 1'b1;
        if (cmd_rdata_i[STS_ANDONE]) begin
          state_d = ST_FINISH;
          fail_d  = cmd_rdata_i[STS_RFAULT]; fail_en = 1'b1;
        end else if (poll_q == AN_LAST) begin
          state_d = ST_FINISH;
          fail_d  = 1'b1; fail_en = 1'b1;
        end else begin
          state_d = ST_AN_WAIT;
          poll_d  = poll_q + 1'b1; poll_en = 1'b1;
        end
      end
      ST_AN_WAIT: if (tick_i) state_d = stat_q[STS_RFAULT] ? ST_FLT_WR : ST_AN_RD;
      ST_FLT_WR:  if (xfer) state_d = ST_AN_RD;
      ST_FINISH:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      poll_q  <= '0;
      stat_q  <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (poll_en) poll_q <= poll_d;
      if (stat_en) stat_q <= stat_d;
      if (fail_en) fail_q <= fail_d;
    end
  end

  AST_START_RESET_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i) |=>
      (cmd_req_o && cmd_wr_o && cmd_reg_o == REG_CTRL && cmd_wdata_o == WORD_RESET))
    else $error("run did not open with reset write"); // R1

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_wr_o && cmd_reg_o == REG_MASK) |-> (cmd_wdata_o == WORD_MASKALL))
    else $error("mask write not all ones"); // R4

  AST_ADV_SELECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && cmd_wr_o && cmd_reg_o == REG_ADV) |-> (cmd_wdata_o[4:0] == 5'b00001))
    else $error("advertisement selector wrong"); // R5

  AST_AN_TIMEOUT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AN_RD && xfer && !cmd_rdata_i[STS_ANDONE] && poll_q == AN_LAST) |=>
      (done_o && fail_o))
    else $error("negotiation timeout not flagged"); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !cmd_req_o)) else $error("done longer than one cycle"); // R11

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && !cmd_ack_i) |=>
      (cmd_req_o && $stable(cmd_wr_o) && $stable(cmd_reg_o) && $stable(cmd_wdata_o)))
    else $error("command changed before acknowledge"); // R12

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int unsigned TICK_CYCLES  = 50_000_000,
  parameter int          RST_POLLS    = 6,
  parameter int          AN_TIMEOUT_S = 5,
  parameter logic [4:0]  REG_CTRL     = 5'd0,
  parameter logic [4:0]  REG_STAT     = 5'd1,
  parameter logic [4:0]  REG_ADV      = 5'd4,
  parameter logic [4:0]  REG_MASK     = 5'd19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        cmd_req_o,
  output logic        cmd_wr_o,
  output logic [4:0]  cmd_reg_o,
  output logic [15:0] cmd_wdata_o,
  input  logic        cmd_ack_i,
  input  logic [15:0] cmd_rdata_i,
  output logic        done_o,
  output logic        fail_o,
  output logic [15:0] status_o
);

  localparam int AN_POLLS = 2 * AN_TIMEOUT_S;

  logic [1:0]  rsync_q;
  logic        rst_int_n;
  logic        tick;
  logic        run;
  logic [15:0] adv_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  bringup_interval_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .tick_o (tick)
  );

  bringup_adv_map u_adv (
    .ability_i (status_o),
    .adv_o     (adv_word)
  );

  bringup_fsm #(
    .RST_POLLS (RST_POLLS),
    .AN_POLLS  (AN_POLLS),
    .REG_CTRL  (REG_CTRL),
    .REG_STAT  (REG_STAT),
    .REG_ADV   (REG_ADV),
    .REG_MASK  (REG_MASK)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .tick_i      (tick),
    .run_o       (run),
    .adv_i       (adv_word),
    .cmd_req_o   (cmd_req_o),
    .cmd_wr_o    (cmd_wr_o),
    .cmd_reg_o   (cmd_reg_o),
    .cmd_wdata_o (cmd_wdata_o),
    .cmd_ack_i   (cmd_ack_i),
    .cmd_rdata_i (cmd_rdata_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .status_o    (status_o)
  );

endmodule

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb;

  localparam int TICK   = 16;
  localparam int RPOLLS = 6;
  localparam int ANS    = 2;
  localparam int APOLLS = 2 * ANS;
  localparam logic [4:0] RC = 5'd0, RS = 5'd1, RA = 5'd4, RM = 5'd19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        cmd_req, cmd_wr, cmd_ack;
  logic [4:0]  cmd_reg;
  logic [15:0] cmd_wdata, cmd_rdata;
  logic        done, fail;
  logic [15:0] status;

  always #2.5 clk = ~clk;

  phy_bringup_seq #(
    .TICK_CYCLES(TICK), .RST_POLLS(RPOLLS), .AN_TIMEOUT_S(ANS),
    .REG_CTRL(RC), .REG_STAT(RS), .REG_ADV(RA), .REG_MASK(RM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cmd_req_o(cmd_req), .cmd_wr_o(cmd_wr), .cmd_reg_o(cmd_reg), .cmd_wdata_o(cmd_wdata),
    .cmd_ack_i(cmd_ack), .cmd_rdata_i(cmd_rdata),
    .done_o(done), .fail_o(fail), .status_o(status)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;

  // scenario
  int          busy;
  logic [15:0] abil;
  logic [3:0]  pcmp, pflt;

  // observed and expected command logs
  logic        lwr [64];
  logic [4:0]  lreg[64];
  logic [15:0] ldat[64];
  int          nlog;
  logic        ewr [64];
  logic [4:0]  ereg[64];
  logic [15:0] edat[64];
  string       etag[64];
  int          nexp;
  logic        efail;
  logic [15:0] estat;
  string       efail_tag;

  int          ctrl_rd, stat_rd, last_ctrl_ack, last_stat_ack;
  logic [15:0] adv_mem;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] adv_of(input logic [15:0] s);
    adv_of = 16'h0001 | ({15'd0, s[15]} << 9) | ({15'd0, s[14]} << 8) |
             ({15'd0, s[13]} << 7) | ({15'd0, s[12]} << 6) | ({15'd0, s[11]} << 5);
  endfunction

  task automatic push(input logic w, input logic [4:0] r, input logic [15:0] d, input string t);
    ewr[nexp] = w; ereg[nexp] = r; edat[nexp] = d; etag[nexp] = t;
    nexp++;
  endtask

  task automatic build_expected();
    logic [15:0] st;
    nexp = 0; efail = 1'b0; estat = 16'h0; efail_tag = "R7";
    push(1'b1, RC, 16'h8000, "R1");
    for (int i = 0; i < RPOLLS; i++) begin
      push(1'b0, RC, 16'h0, "R2");
      if (i >= busy) break;
      if (i == RPOLLS - 1) begin
        efail = 1'b1; estat = 16'h0; efail_tag = "R3";
        return;
      end
    end
    push(1'b1, RM, 16'hFFFF, "R4");
    push(1'b0, RS, 16'h0, "R4");
    push(1'b1, RA, adv_of(abil), "R5");
    push(1'b0, RA, 16'h0, "R6");
    push(1'b1, RC, 16'h1200, "R6");
    for (int p = 0; p < APOLLS; p++) begin
      push(1'b0, RS, 16'h0, "R7");
      st = abil | ({15'd0, pcmp[p]} << 5) | ({15'd0, pflt[p]} << 4);
      estat = st;
      if (pcmp[p]) begin
        efail = pflt[p]; efail_tag = pflt[p] ? "R10" : "R7";
        return;
      end
      if (p == APOLLS - 1) begin
        efail = 1'b1; efail_tag = "R9";
        return;
      end
      if (pflt[p]) push(1'b1, RC, 16'h3300, "R8");
    end
  endtask

  // PHY-side responder with random acknowledge latency
  initial begin
    logic        w0;
    logic [4:0]  r0;
    logic [15:0] d0, rd;
    int          lat, idx;
    cmd_ack = 1'b0;
    cmd_rdata = 16'h0;
    forever begin
      @(negedge clk);
      if (cmd_req && rst_n) begin
        w0 = cmd_wr; r0 = cmd_reg; d0 = cmd_wdata;
        lat = int'($urandom % 3);
        repeat (lat) @(negedge clk);
        check(cmd_req && cmd_wr == w0 && cmd_reg == r0 && cmd_wdata == d0, "R12",
              "command held until ack", {10'd0, cmd_wr, cmd_reg, cmd_wdata}, {10'd0, w0, r0, d0});
        rd = 16'h0;
        if (!w0 && r0 == RC) begin
          rd = (ctrl_rd < busy) ? 16'h8000 : 16'h0000;
          if (last_ctrl_ack >= 0)
            check(cyc - last_ctrl_ack >= TICK, "R2", "reset poll spacing",
                  32'(cyc - last_ctrl_ack), 32'(TICK));
          last_ctrl_ack = cyc;
          ctrl_rd++;
        end else if (!w0 && r0 == RS) begin
          if (stat_rd == 0) rd = abil;
          else begin
            idx = stat_rd - 1;
            rd = abil;
            if (idx < 4) rd = abil | ({15'd0, pcmp[idx]} << 5) | ({15'd0, pflt[idx]} << 4);
            if (stat_rd >= 2)
              check(cyc - last_stat_ack >= TICK, "R7", "status poll spacing",
                    32'(cyc - last_stat_ack), 32'(TICK));
          end
          last_stat_ack = cyc;
          stat_rd++;
        end else if (!w0 && r0 == RA) begin
          rd = adv_mem;
        end else if (w0 && r0 == RA) begin
          adv_mem = d0;
        end
        if (nlog < 64) begin
          lwr[nlog] = w0; lreg[nlog] = r0; ldat[nlog] = d0;
        end
        nlog++;
        cmd_rdata = rd;
        cmd_ack = 1'b1;
        @(negedge clk);
        cmd_ack = 1'b0;
        cmd_rdata = 16'h0;
      end
    end
  end

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && done) done_cnt++;

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_scn(input int b, input logic [15:0] ab, input logic [3:0] c,
                         input logic [3:0] f, input bit poke);
    int n;
    busy = b; abil = ab & 16'hFFCF; pcmp = c; pflt = f;
    build_expected();
    nlog = 0; ctrl_rd = 0; stat_rd = 0; last_ctrl_ack = -1; last_stat_ack = -1;
    adv_mem = 16'h0; done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (done_cnt > 0) break;
      if (poke && k == 20) start = 1'b1;
      if (poke && k == 21) start = 1'b0;
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    check(done_cnt == 1, "R11", "done high cycles", 32'(done_cnt), 32'd1);
    check(nlog == nexp, (nexp > 0) ? etag[nexp-1] : "R1", "command count", 32'(nlog), 32'(nexp));
    n = (nlog < nexp) ? nlog : nexp;
    if (n > 64) n = 64;
    for (int i = 0; i < n; i++) begin
      if (lwr[i] != ewr[i] || lreg[i] != ereg[i] || (ewr[i] && ldat[i] != edat[i])) begin
        check(1'b0, etag[i], $sformatf("command %0d", i),
              {11'd0, lwr[i], lreg[i], (lwr[i] ? ldat[i] : 16'h0)},
              {11'd0, ewr[i], ereg[i], (ewr[i] ? edat[i] : 16'h0)});
        break;
      end
      if (i == n - 1) check(1'b1, "R1", "command sequence", 32'd0, 32'd0);
    end
    check(fail == efail, efail_tag, "fail verdict", {31'd0, fail}, {31'd0, efail});
    check(status == estat, "R7", "last status word", {16'd0, status}, {16'd0, estat});
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    start = 1'b0;
    busy = 0; abil = 16'h0; pcmp = 4'h0; pflt = 4'h0;
    nlog = 0; ctrl_rd = 0; stat_rd = 0; last_ctrl_ack = -1; last_stat_ack = -1; adv_mem = 16'h0;
    repeat (3) @(negedge clk);
    check(!cmd_req && !done && !fail && status == 16'h0, "R13", "reset outputs",
          {13'd0, cmd_req, done, fail, status}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_scn(0, 16'hF800, 4'b0001, 4'b0000, 1'b0);   // R7 quick success, all abilities
    run_scn(6, 16'h7800, 4'b0001, 4'b0000, 1'b0);   // R3 reset never clears
    run_scn(5, 16'h9000, 4'b0010, 4'b0000, 1'b0);   // R2 clears on last allowed read
    run_scn(1, 16'h2800, 4'b0000, 4'b0000, 1'b1);   // R9 timeout, R11 start ignored mid-run
    run_scn(0, 16'h4000, 4'b0100, 4'b0011, 1'b0);   // R8 faults then clean completion
    run_scn(2, 16'h0000, 4'b0001, 4'b0001, 1'b0);   // R10 complete with fault, R5 selector only
    run_scn(0, 16'hA800, 4'b0000, 4'b1111, 1'b0);   // R9 with R8 fault kicks throughout
    for (int s = 0; s < 12; s++)
      run_scn(int'($urandom % 8), 16'($urandom), 4'($urandom), 4'($urandom), 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule